// File: doc/BRIEF.md
# QPSK Integrate-and-Dump Demodulator

This block recovers the two hard-decision bits of a QPSK carrier from a stream of unsigned samples. Each sample arrives together with a locally generated cosine reference and sine reference. Both references, like the sample itself, are offset-binary: the sinusoid is lifted by one full amplitude so every value is non-negative. On the transmit side an in-phase bit of 0 sends +cos and a 1 sends -cos. A quadrature bit of 0 sends +sin and a 1 sends -sin. The line carries the sum of the two channels.

The demodulator multiplies the sample by each reference and adds the products into two accumulators. After every dump, only a programmable number of sample cycles is added. That window is meant to be longer than a carrier cycle and shorter than a code chip. On the rising edge of the code clock, each accumulator is compared against its own unsigned threshold. A sum above the threshold is decoded as 0, and any other sum as 1. Both accumulators then clear for the next chip. The two bits leave with a one-cycle valid strobe. Because a decision summarises the chip that has just ended, the recovered bits trail the transmitted ones by one code-clock period.

Carrier synthesis, phase tracking and despreading are outside this block.

Top module: `qpsk_iad_demod`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `bit_i`, `bit_q` and `bit_vld` are 0.
- R2: The I accumulator adds the unsigned product `smp_in*cos_ref` and the Q accumulator adds the unsigned product `smp_in*sin_ref`, each on its own.
- R3: After a dump, only the first `win_len` clock edges add their products. Later edges leave the sums unchanged until the next dump. With `win_len` = 0, nothing is added.
- R4: A decision is taken on the clock edge at which `code_clk` is sampled high after being sampled low on the previous edge. The bits change on that edge and reflect the samples since the previous decision, giving one code period of lag.
- R5: Each channel decodes 0 when its sum is strictly greater than its threshold (`thr_i` for I, `thr_q` for Q, both zero-extended). It decodes 1 when the sum is less than or equal to the threshold.
- R6: On the decision edge both accumulators load zero. The product presented on that edge is discarded.
- R7: The accumulators are SAMPLE_W+REF_W+PERIOD_W bits wide, so a full window of maximum products never wraps.
- R8: `bit_vld` is high for exactly the one cycle after each decision edge. `bit_i` and `bit_q` hold their values between decisions.
- R9: Holding `code_clk` high for several cycles yields only one decision, and accumulation continues while it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_in | input | SAMPLE_W | Unsigned offset-binary QPSK sample |
| cos_ref | input | REF_W | Unsigned local cosine reference |
| sin_ref | input | REF_W | Unsigned local sine reference |
| code_clk | input | 1 | Code clock level; its rising edge triggers decide-and-dump |
| win_len | input | PERIOD_W | Number of sample cycles accumulated after each dump |
| thr_i | input | THR_W | Unsigned decision threshold for I |
| thr_q | input | THR_W | Unsigned decision threshold for Q |
| bit_i | output | 1 | Recovered in-phase bit |
| bit_q | output | 1 | Recovered quadrature bit |
| bit_vld | output | 1 | One-cycle strobe marking a new decision |

## Verification
The bench builds the block with its default widths: 8-bit samples and references, an 8-bit window and 16-bit thresholds. These defaults let a window of 255 full-scale products (16,581,375) be driven, which exercises the 24-bit accumulator width directly.

The sweep crosses window lengths of 0, 1, 3, 17 and 255 with code-clock spacings from 2 to 300 cycles, so the window both ends before and is cut short by the next decision. The bench places each threshold exactly at the expected sum, one below it, at zero, or at full scale. This reaches the equality boundary of the slicer on both channels independently, and some runs hold `code_clk` high for several cycles.

// File: rtl/qid_pkg.sv
// Shared definitions for the QPSK integrate-and-dump demodulator.
// Assumes exactly two quadrature channels.
package qid_pkg;
    localparam int NUM_CH = 2;

    typedef enum int {
        CH_I = 0,
        CH_Q = 1
    } chan_e;
endpackage

// File: rtl/qid_edge.sv
// Code-clock edge detector: registers the code clock level and flags the
// cycle in which it is high after being low on the previous edge.
// Assumes code_clk is synchronous to clk.
module qid_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic code_clk,
    output logic rise
);
    logic code_q;

    // Remember the code clock level seen on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= 1'b0;
        else        code_q <= code_clk;
    end

    // Rising edge is a high level now with a low level before.
    always_comb rise = code_clk && !code_q;
endmodule

// File: rtl/qid_window.sv
// Accumulation window counter: after each dump, asserts acc_en for win_len
// clock edges and then holds it low until the next dump.
// Assumes win_len is stable within a code period.
module qid_window #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dump,
    input  logic [PERIOD_W-1:0] win_len,
    output logic                acc_en
);
    logic [PERIOD_W-1:0] cnt;

    // Count accumulated cycles since the last dump, saturating at win_len.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (dump)           cnt <= '0;
        else if (cnt < win_len)  cnt <= cnt + 1'b1;
    end

    // Products are accepted only inside the window and never on a dump edge.
    always_comb acc_en = !dump && (cnt < win_len);
endmodule

// File: rtl/qid_channel.sv
// One demodulator arm: multiplies the sample by its reference, integrates
// the product while enabled, and on dump slices the sum against a threshold
// and clears. Assumes ACC_W is at least THR_W and wide enough for a full window.
module qid_channel #(
    parameter int SAMPLE_W = 8,
    parameter int REF_W    = 8,
    parameter int THR_W    = 16,
    parameter int ACC_W    = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] smp,
    input  logic [REF_W-1:0]    ref_v,
    input  logic                acc_en,
    input  logic                dump,
    input  logic [THR_W-1:0]    thr,
    output logic [ACC_W-1:0]    acc,
    output logic                bit_o
);
    localparam int PROD_W = SAMPLE_W + REF_W;

    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  prod_ext;
    logic [ACC_W-1:0]  thr_ext;
    logic              above;

    // Unsigned product and extensions to accumulator width.
    always_comb begin
        prod     = PROD_W'(smp) * PROD_W'(ref_v);
        prod_ext = ACC_W'(prod);
        thr_ext  = ACC_W'(thr);
        above    = acc > thr_ext;
    end

    // Integrate, then slice and clear on dump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            bit_o <= 1'b0;
        end else if (dump) begin
            acc   <= '0;
            bit_o <= !above;
        end else if (acc_en) begin
            acc   <= acc + prod_ext;
        end
    end
endmodule

// File: rtl/qpsk_iad_demod.sv
// QPSK integrate-and-dump demodulator top: shares the code-clock edge and
// the window counter between an I arm (cosine) and a Q arm (sine), and
// emits a one-cycle strobe with each decision.
// Assumes all inputs are synchronous to clk.
module qpsk_iad_demod #(
    parameter int SAMPLE_W = 8,
    parameter int REF_W    = 8,
    parameter int PERIOD_W = 8,
    parameter int THR_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] smp_in,
    input  logic [REF_W-1:0]    cos_ref,
    input  logic [REF_W-1:0]    sin_ref,
    input  logic                code_clk,
    input  logic [PERIOD_W-1:0] win_len,
    input  logic [THR_W-1:0]    thr_i,
    input  logic [THR_W-1:0]    thr_q,
    output logic                bit_i,
    output logic                bit_q,
    output logic                bit_vld
);
    import qid_pkg::*;

    localparam int ACC_W = SAMPLE_W + REF_W + PERIOD_W;

    logic             dump;
    logic             acc_en;
    logic [REF_W-1:0] ref_sel [NUM_CH];
    logic [THR_W-1:0] thr_sel [NUM_CH];
    logic [ACC_W-1:0] acc_w   [NUM_CH];
    logic             bit_w   [NUM_CH];

    qid_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_clk (code_clk),
        .rise     (dump)
    );

    qid_window #(.PERIOD_W(PERIOD_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .dump    (dump),
        .win_len (win_len),
        .acc_en  (acc_en)
    );

    // Route each arm its reference and threshold.
    always_comb begin
        ref_sel[CH_I] = cos_ref;
        ref_sel[CH_Q] = sin_ref;
        thr_sel[CH_I] = thr_i;
        thr_sel[CH_Q] = thr_q;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        qid_channel #(
            .SAMPLE_W (SAMPLE_W),
            .REF_W    (REF_W),
            .THR_W    (THR_W),
            .ACC_W    (ACC_W)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp    (smp_in),
            .ref_v  (ref_sel[c]),
            .acc_en (acc_en),
            .dump   (dump),
            .thr    (thr_sel[c]),
            .acc    (acc_w[c]),
            .bit_o  (bit_w[c])
        );
    end

    // Decision strobe follows each dump by the same edge that updates the bits.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_vld <= 1'b0;
        else        bit_vld <= dump;
    end

    // Drive the recovered bits from the arms.
    always_comb begin
        bit_i = bit_w[CH_I];
        bit_q = bit_w[CH_Q];
    end
endmodule

// File: rtl/qid_checker.sv
// Property checker for qpsk_iad_demod, bound to every instance.
module qid_checker #(
    parameter int ACC_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             code_clk,
    input logic             bit_i,
    input logic             bit_q,
    input logic             bit_vld,
    input logic [ACC_W-1:0] acc_i,
    input logic [ACC_W-1:0] acc_q
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> !bit_vld); // R8

    AST_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |-> ($stable(bit_i) && $stable(bit_q))); // R8

    AST_DUMP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> (acc_i == '0 && acc_q == '0)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |-> (acc_i >= $past(acc_i) && acc_q >= $past(acc_q))); // R7

    AST_DECIDE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (code_clk && !$past(code_clk)) |=> bit_vld); // R4
endmodule

bind qpsk_iad_demod qid_checker #(.ACC_W(SAMPLE_W + REF_W + PERIOD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_clk (code_clk),
    .bit_i    (bit_i),
    .bit_q    (bit_q),
    .bit_vld  (bit_vld),
    .acc_i    (acc_w[0]),
    .acc_q    (acc_w[1])
);

// File: tb/qpsk_iad_demod_tb.sv
`timescale 1ns/1ps
module qpsk_iad_demod_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  smp_in = '0;
    logic [7:0]  cos_ref = '0;
    logic [7:0]  sin_ref = '0;
    logic        code_clk = 1'b0;
    logic [7:0]  win_len = '0;
    logic [15:0] thr_i = '0;
    logic [15:0] thr_q = '0;
    logic        bit_i, bit_q, bit_vld;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    logic [31:0] seed = 32'h1357_9bdf;

    always #2.5 clk = ~clk;

    qpsk_iad_demod u_dut (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .cos_ref(cos_ref),
        .sin_ref(sin_ref), .code_clk(code_clk), .win_len(win_len),
        .thr_i(thr_i), .thr_q(thr_q), .bit_i(bit_i), .bit_q(bit_q),
        .bit_vld(bit_vld)
    );

    task automatic chk(input string tag, input longint got, input longint exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Threshold policy: 0 equal to sum, 1 one below, 2 zero, 3 full scale.
    function automatic longint pick_thr(input longint sum, input int pol);
        case (pol)
            0:       return (sum > 65535) ? 65535 : sum;
            1:       return (sum == 0) ? 0 : ((sum - 1 > 65535) ? 65535 : sum - 1);
            2:       return 0;
            default: return 65535;
        endcase
    endfunction

    // Precondition: at a negedge right after a decision edge.
    task automatic window(input int per, input int gap, input int hold,
                          input bit rnd, input int s0, input int c0, input int q0,
                          input int pi_, input int pq_);
        longint si = 0, sq = 0, ti, tq;
        win_len = 8'(per);
        for (int k = 1; k < gap; k++) begin
            code_clk = (k <= hold);
            if (rnd) begin
                seed = step(seed);
                smp_in = seed[7:0]; cos_ref = seed[15:8]; sin_ref = seed[23:16];
            end else begin
                smp_in = 8'(s0); cos_ref = 8'(c0); sin_ref = 8'(q0);
            end
            if (k <= per) begin
                si += longint'(smp_in) * longint'(cos_ref);
                sq += longint'(smp_in) * longint'(sin_ref);
            end
            if (k == 2) chk($sformatf("R8/R9 no strobe inside window per=%0d gap=%0d", per, gap),
                            bit_vld, 0);
            @(negedge clk);
        end
        ti = pick_thr(si, pi_);
        tq = pick_thr(sq, pq_);
        thr_i = 16'(ti); thr_q = 16'(tq);
        code_clk = 1'b1;
        seed = step(seed);
        smp_in = seed[7:0]; cos_ref = seed[15:8]; sin_ref = seed[23:16]; // R6 discarded
        @(negedge clk);
        chk($sformatf("R4/R8 strobe at decision per=%0d gap=%0d", per, gap), bit_vld, 1);
        chk($sformatf("R2/R3/R5 I bit per=%0d gap=%0d sum=%0d thr=%0d", per, gap, si, ti),
            bit_i, (si > ti) ? 0 : 1);
        chk($sformatf("R2/R3/R5 Q bit per=%0d gap=%0d sum=%0d thr=%0d", per, gap, sq, tq),
            bit_q, (sq > tq) ? 0 : 1);
    endtask

    initial begin
        int pers[5] = '{0, 1, 3, 17, 255};
        int gaps[5] = '{2, 3, 6, 40, 300};
        int idx = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset bit_i", bit_i, 0);
        chk("R1 reset bit_q", bit_q, 0);
        chk("R1 reset bit_vld", bit_vld, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset bit_vld", bit_vld, 0);
        chk("R1 after reset bit_i", bit_i, 0);
        // Priming decision clears whatever accumulated since reset.
        code_clk = 1'b1;
        @(negedge clk);
        chk("R4 priming strobe", bit_vld, 1);
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                window(pers[a], gaps[b], (gaps[b] > 5 && idx % 3 == 0) ? 3 : 0,
                       1'b1, 0, 0, 0, idx % 4, (idx + 1) % 4);
                idx++;
            end
        end
        // R7 full-scale window: 255*255*255 must stay above full-scale threshold.
        window(255, 300, 0, 1'b0, 255, 255, 255, 3, 3);
        // R3 zero window with large inputs: sums stay zero and decode 1 at threshold 0.
        window(0, 20, 0, 1'b0, 255, 255, 255, 2, 2);
        // R5 equality boundary on small constant sums, I and Q thresholds differ.
        window(4, 10, 0, 1'b0, 10, 20, 30, 0, 1);
        window(4, 10, 0, 1'b0, 10, 20, 30, 1, 0);
        // R9 code clock held high for most of the window.
        window(5, 12, 8, 1'b0, 3, 7, 9, 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule